// File: doc/BRIEF.md
# Dual-Channel Pointer-Indexed Register Port

This block is the host-facing register front end of a two-channel serial controller. Each channel appears to the host as two byte ports only: a control port and a data port. The controller has sixteen write registers and sixteen read registers per channel, and the same index selects different functions for a read and for a write. A host reaches any of them through the control port in two steps. It first writes a register index, and the next control-port access then writes or reads that register. Each channel runs its own small pointer state machine. One master-control write register is common to both channels, and its top two bits request channel or full resets.

The pointer machine of each channel has two states. `PS_IDLE` is left by the transition *load pointer*, which is a control write whose decoded index is nonzero. `PS_ARMED` is left by the transition *complete access*, which is the next control write (register store) or control read (register fetch). Both transitions into the idle state also clear the pointer to 0. A third transition, *channel clear*, forces `PS_IDLE` from either state when that channel is reset. While the machine is idle, a control read returns the channel's live status byte (read register 0). A control write that decodes to index 0 leaves the machine in `PS_IDLE`.

Data-port accesses pass transmit bytes out to the serial engine and fetch received bytes from it. They never move the pointer.

Top module: `sio_regport`

## Requirements
- R1: After reset every write register of both channels and the master-control register are 0, both pointer machines are idle, and `host_rdata`, `tx_load`, `rx_take` and `chan_rst` are 0.
- R2: `host_addr[2]` selects the channel (1 = channel A, 0 = channel B), and `host_addr[1]` selects the port (0 = control, 1 = data). An access happens on a clock edge where `host_stb` is 1, and `host_we` is 1 for a write.
- R3: A control write in the idle state loads the index from bits 2:0. The value 8 is added only when bits 5:3 equal 3'b001; any other code in bits 5:3 adds nothing. The following control write stores its byte in the selected write register and returns the pointer to 0.
- R4: A control read returns the read register selected by the pointer and then returns the pointer to 0. A control read in the idle state returns read register 0, which is the channel's `line_stat` byte. Read data appears on `host_rdata` the cycle after the access and holds until the next read.
- R5: The read map is as follows. RR1 is `rx_err` and RR8 is `rx_byte`. RR2, RR4, RR5, RR12 and RR13 mirror the write registers of the same index. RR9 mirrors WR3, RR11 mirrors WR10, RR14 mirrors WR7 and RR15 mirrors WR15. RR6, RR7 and RR10 read 0.
- R6: RR3 returns `irq_pend` on channel A and always reads 0 on channel B.
- R7: WR9 is one register shared by both channels and can be written through either channel. `master_ctl` shows its bits 5:0, and bits 7:6 read as 0.
- R8: WR9 bits 7:6 are a reset code: 2'b10 resets channel A, 2'b01 resets channel B, and 2'b11 resets both channels and clears WR9. `chan_rst` (bit 1 = A, bit 0 = B) pulses for one cycle after the write.
- R9: A reset of one channel zeroes that channel's write registers and returns its pointer to 0. It leaves the other channel and WR9's bits 5:0 (taken from the same write) untouched.
- R10: A control write that decodes to index 0 stores nothing and leaves the pointer idle, so the next control read returns RR0.
- R11: A data-port write pulses that channel's bit of `tx_load` for one cycle and puts the byte on `tx_byte`. A data-port read returns that channel's `rx_byte` and pulses `rx_take`. Neither access changes the pointer.
- R12: `brg_const` shows each channel's baud time constant {WR13, WR12}. Channel A is in bits 31:16 and channel B in bits 15:0.
- R13: The two channels keep independent pointers: loading a pointer on one channel does not change what the other channel's next control access selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_stb | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | [2] channel A select, [1] data port select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| line_stat | input | 16 | Status byte per channel (A high), bit0 rx available, bit1 zero count, bit2 tx empty, bit3 DCD, bit5 CTS, bit6 tx underrun, bit7 break |
| rx_err | input | 16 | Receive condition byte per channel (A high) |
| rx_byte | input | 16 | Received byte per channel (A high) |
| irq_pend | input | 8 | Interrupt pending byte, channel A only |
| tx_byte | output | 8 | Byte written to a data port |
| tx_load | output | 2 | Transmit load pulse per channel (bit 1 = A) |
| rx_take | output | 2 | Receive fetch pulse per channel (bit 1 = A) |
| brg_const | output | 32 | Baud time constants, A in 31:16 |
| master_ctl | output | 8 | Shared master-control register |
| chan_rst | output | 2 | Channel reset pulse (bit 1 = A) |

## Verification
The bench drives random sequences of indirect writes, indirect reads, data-port accesses and master-control writes on both channels. It compares each read against a model of both register maps, so a wrong index decode, a map swap between the read and write sides, or a pointer that fails to return to 0 shows up as a wrong byte. Directed cases separate out the cases that random stimulus rarely hits. These are an idle read against an armed read, index-0 and non-point-high modifier bytes, a pointer left armed on one channel while the other is used, a data access between the pointer and the register access, and each reset code followed by readback of both channels.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [0:0] {
        PS_IDLE  = 1'b0,
        PS_ARMED = 1'b1
    } ptr_state_e;

    localparam int CH_B = 0;
    localparam int CH_A = 1;

    localparam int IDX_MIC  = 9;
    localparam int IDX_PEND = 3;

    // Modifier code in pointer bits 5:3 that selects the upper bank
    localparam logic [2:0] MOD_HIGH = 3'b001;

    // Reset codes carried in bits 7:6 of the shared register
    localparam logic [1:0] RST_NONE = 2'b00;
    localparam logic [1:0] RST_FULL = 2'b11;

endpackage

// File: rtl/sio_ptr_fsm.sv
module sio_ptr_fsm
    import sio_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_clr,
    input  logic             ctl_wr,
    input  logic             ctl_rd,
    input  logic [5:0]       ptr_byte,
    output logic             reg_wr,
    output logic [IDX_W-1:0] acc_idx
);

    ptr_state_e       state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [IDX_W-1:0] decoded;

    always_comb begin
        decoded = IDX_W'(ptr_byte[2:0]);
        if (ptr_byte[5:3] == MOD_HIGH) begin
            decoded = decoded + IDX_W'(8);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        reg_wr  = 1'b0;
        acc_idx = '0;
        unique case (state_q)
            PS_IDLE: begin
                if (ctl_wr && decoded != '0) begin
                    state_d = PS_ARMED;
                    ptr_d   = decoded;
                end
            end
            PS_ARMED: begin
                acc_idx = ptr_q;
                if (ctl_wr) begin
                    reg_wr  = 1'b1;
                    state_d = PS_IDLE;
                    ptr_d   = '0;
                end else if (ctl_rd) begin
                    state_d = PS_IDLE;
                    ptr_d   = '0;
                end
            end
        endcase
        if (ch_clr) begin
            state_d = PS_IDLE;
            ptr_d   = '0;
        end
    end

    // R3
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_ARMED && (ctl_wr || ctl_rd)) |=> (state_q == PS_IDLE && ptr_q == '0));

    // R10
    zero_idx_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_IDLE && ctl_wr && decoded == '0) |=> state_q == PS_IDLE);

endmodule

// File: rtl/sio_chan_regs.sv
module sio_chan_regs
    import sio_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NREG     = 16,
    parameter bit HAS_PEND = 1'b0,
    localparam int IDX_W   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] line_stat,
    input  logic [DATA_W-1:0] rx_err,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] pend,
    output logic [DATA_W-1:0] rd_val,
    output logic [2*DATA_W-1:0] tc
);

    logic [DATA_W-1:0] wr_q [NREG];
    logic [DATA_W-1:0] pend_view;

    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_wr
            if (r == 0 || r == IDX_MIC) begin : g_none
                assign wr_q[r] = '0;
            end else begin : g_store
                always_ff @(posedge clk) begin
                    if (!rst_n || clr) begin
                        wr_q[r] <= '0;
                    end else if (wr_en && wr_idx == IDX_W'(r)) begin
                        wr_q[r] <= wdata;
                    end
                end
            end
        end
        if (HAS_PEND) begin : g_pend
            assign pend_view = pend;
        end else begin : g_nopend
            logic pend_unused;
            assign pend_unused = ^pend;
            assign pend_view   = '0;
        end
    endgenerate

    assign tc = {wr_q[13], wr_q[12]};

    always_comb begin
        case (rd_idx)
            IDX_W'(0):  rd_val = line_stat;
            IDX_W'(1):  rd_val = rx_err;
            IDX_W'(2):  rd_val = wr_q[2];
            IDX_W'(3):  rd_val = pend_view;
            IDX_W'(4):  rd_val = wr_q[4];
            IDX_W'(5):  rd_val = wr_q[5];
            IDX_W'(8):  rd_val = rx_byte;
            IDX_W'(9):  rd_val = wr_q[3];
            IDX_W'(11): rd_val = wr_q[10];
            IDX_W'(12): rd_val = wr_q[12];
            IDX_W'(13): rd_val = wr_q[13];
            IDX_W'(14): rd_val = wr_q[7];
            IDX_W'(15): rd_val = wr_q[15];
            default:    rd_val = '0;
        endcase
    end

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> tc == '0);

    // R12
    tc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && wr_idx == IDX_W'(12)) |=> tc[DATA_W-1:0] == $past(wdata));

endmodule

// File: rtl/sio_master_ctl.sv
module sio_master_ctl
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [1:0]        rst_req,
    output logic [1:0]        rst_pulse,
    output logic [DATA_W-1:0] mic
);

    logic [1:0] code;

    assign code    = wdata[DATA_W-1 -: 2];
    assign rst_req = wr_en ? code : RST_NONE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mic       <= '0;
            rst_pulse <= '0;
        end else begin
            rst_pulse <= rst_req;
            if (wr_en) begin
                if (code == RST_FULL) begin
                    mic <= '0;
                end else begin
                    mic <= {2'b00, wdata[DATA_W-3:0]};
                end
            end
        end
    end

    // R8
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pulse == RST_FULL) |-> mic == '0);

    // R7
    code_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mic[DATA_W-1 -: 2] == 2'b00);

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pulse != RST_NONE && !$past(wr_en)) |-> 1'b0);

endmodule

// File: rtl/sio_regport.sv
module sio_regport
    import sio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREG   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_stb,
    input  logic                  host_we,
    input  logic [2:1]            host_addr,
    input  logic [DATA_W-1:0]     host_wdata,
    output logic [DATA_W-1:0]     host_rdata,
    input  logic [2*DATA_W-1:0]   line_stat,
    input  logic [2*DATA_W-1:0]   rx_err,
    input  logic [2*DATA_W-1:0]   rx_byte,
    input  logic [DATA_W-1:0]     irq_pend,
    output logic [DATA_W-1:0]     tx_byte,
    output logic [1:0]            tx_load,
    output logic [1:0]            rx_take,
    output logic [4*DATA_W-1:0]   brg_const,
    output logic [DATA_W-1:0]     master_ctl,
    output logic [1:0]            chan_rst
);

    localparam int NCH   = 2;
    localparam int IDX_W = $clog2(NREG);

    logic             is_data;
    logic [NCH-1:0]   ch_sel, ctl_wr, ctl_rd, reg_wr, mic_hit, ch_clr;
    logic [IDX_W-1:0] acc_idx [NCH];
    logic [DATA_W-1:0] rd_val [NCH];
    logic [1:0]       rst_req;
    logic             mic_wr;
    logic [DATA_W-1:0] rd_next;

    assign is_data = host_addr[1];

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            assign ch_sel[c]  = host_stb && (host_addr[2] == (c == CH_A));
            assign ctl_wr[c]  = ch_sel[c] && !is_data && host_we;
            assign ctl_rd[c]  = ch_sel[c] && !is_data && !host_we;
            assign mic_hit[c] = reg_wr[c] && acc_idx[c] == IDX_W'(IDX_MIC);
            assign ch_clr[c]  = rst_req[c];

            sio_ptr_fsm #(.IDX_W(IDX_W)) u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .ch_clr   (ch_clr[c]),
                .ctl_wr   (ctl_wr[c]),
                .ctl_rd   (ctl_rd[c]),
                .ptr_byte (host_wdata[5:0]),
                .reg_wr   (reg_wr[c]),
                .acc_idx  (acc_idx[c])
            );

            sio_chan_regs #(
                .DATA_W   (DATA_W),
                .NREG     (NREG),
                .HAS_PEND (c == CH_A)
            ) u_regs (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr       (ch_clr[c]),
                .wr_en     (reg_wr[c]),
                .wr_idx    (acc_idx[c]),
                .wdata     (host_wdata),
                .rd_idx    (acc_idx[c]),
                .line_stat (line_stat[c*DATA_W +: DATA_W]),
                .rx_err    (rx_err[c*DATA_W +: DATA_W]),
                .rx_byte   (rx_byte[c*DATA_W +: DATA_W]),
                .pend      (irq_pend),
                .rd_val    (rd_val[c]),
                .tc        (brg_const[c*2*DATA_W +: 2*DATA_W])
            );
        end
    endgenerate

    assign mic_wr = |mic_hit;

    sio_master_ctl #(.DATA_W(DATA_W)) u_mic (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mic_wr),
        .wdata     (host_wdata),
        .rst_req   (rst_req),
        .rst_pulse (chan_rst),
        .mic       (master_ctl)
    );

    always_comb begin
        if (host_addr[2]) begin
            rd_next = is_data ? rx_byte[CH_A*DATA_W +: DATA_W] : rd_val[CH_A];
        end else begin
            rd_next = is_data ? rx_byte[CH_B*DATA_W +: DATA_W] : rd_val[CH_B];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
            tx_byte    <= '0;
            tx_load    <= '0;
            rx_take    <= '0;
        end else begin
            tx_load <= '0;
            rx_take <= '0;
            if (host_stb && !host_we) begin
                host_rdata <= rd_next;
            end
            if (host_stb && is_data) begin
                if (host_we) begin
                    tx_byte <= host_wdata;
                    tx_load <= ch_sel;
                end else begin
                    rx_take <= ch_sel;
                end
            end
        end
    end

    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_stb && !host_we) |-> $stable(host_rdata));

    // R6
    rr3_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd[CH_B] && acc_idx[CH_B] == IDX_W'(IDX_PEND)) |=> host_rdata == '0);

    // R9
    other_chan_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rst == 2'b10) |-> $stable(brg_const[2*DATA_W-1:0]));

    // R11
    tx_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_load) && $onehot0(rx_take));

endmodule

// File: tb/sio_regport_tb.sv
module sio_regport_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_stb, host_we;
    logic [2:1]  host_addr;
    logic [7:0]  host_wdata, host_rdata;
    logic [15:0] line_stat, rx_err, rx_byte;
    logic [7:0]  irq_pend, tx_byte, master_ctl;
    logic [1:0]  tx_load, rx_take, chan_rst;
    logic [31:0] brg_const;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] m_wr [2][16];
    logic [7:0] m_mic;
    logic [1:0] snap_tx, snap_take, snap_rst;

    always #2 clk = ~clk;

    sio_regport u_dut (
        .clk(clk), .rst_n(rst_n), .host_stb(host_stb), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .line_stat(line_stat), .rx_err(rx_err), .rx_byte(rx_byte),
        .irq_pend(irq_pend), .tx_byte(tx_byte), .tx_load(tx_load),
        .rx_take(rx_take), .brg_const(brg_const), .master_ctl(master_ctl),
        .chan_rst(chan_rst)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rr(input int ch, input int idx);
        case (idx)
            0:  return line_stat[ch*8 +: 8];
            1:  return rx_err[ch*8 +: 8];
            2:  return m_wr[ch][2];
            3:  return (ch == 1) ? irq_pend : 8'h00;
            4:  return m_wr[ch][4];
            5:  return m_wr[ch][5];
            8:  return rx_byte[ch*8 +: 8];
            9:  return m_wr[ch][3];
            11: return m_wr[ch][10];
            12: return m_wr[ch][12];
            13: return m_wr[ch][13];
            14: return m_wr[ch][7];
            15: return m_wr[ch][15];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] pbyte(input int idx);
        return (idx >= 8) ? (8'h08 | 8'(idx & 7)) : 8'(idx & 7);
    endfunction

    task automatic clear_chan(input int ch);
        for (int i = 0; i < 16; i++) m_wr[ch][i] = 8'h00;
    endtask

    task automatic acc(input int ch, input bit data, input bit we,
                       input logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        host_stb   = 1'b1;
        host_we    = we;
        host_addr  = {ch[0], data};
        host_wdata = wd;
        @(negedge clk);
        rd        = host_rdata;
        snap_tx   = tx_load;
        snap_take = rx_take;
        snap_rst  = chan_rst;
        host_stb  = 1'b0;
        host_we   = 1'b0;
    endtask

    task automatic wreg(input int ch, input int idx, input logic [7:0] val);
        logic [7:0] d;
        acc(ch, 1'b0, 1'b1, pbyte(idx), d);
        acc(ch, 1'b0, 1'b1, val, d);
        if (idx == 9) begin
            chk(snap_rst == val[7:6], "R8 reset pulse", 32'(snap_rst), 32'(val[7:6]));
            if (val[7:6] == 2'b11) begin
                clear_chan(0); clear_chan(1); m_mic = 8'h00;
            end else begin
                m_mic = {2'b00, val[5:0]};
                if (val[7]) clear_chan(1);
                if (val[6]) clear_chan(0);
            end
        end else if (idx != 0) begin
            m_wr[ch][idx] = val;
        end
    endtask

    task automatic rreg(input int ch, input int idx, input string req);
        logic [7:0] d;
        acc(ch, 1'b0, 1'b1, pbyte(idx), d);
        acc(ch, 1'b0, 1'b0, 8'h00, d);
        chk(d == exp_rr(ch, idx), req, 32'(d), 32'(exp_rr(ch, idx)));
    endtask

    task automatic chk_outs(input string req);
        logic [31:0] e;
        e = {m_wr[1][13], m_wr[1][12], m_wr[0][13], m_wr[0][12]};
        chk(brg_const == e, req, brg_const, e);
        chk(master_ctl == m_mic, req, 32'(master_ctl), 32'(m_mic));
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h1A2B3C4D));
        host_stb = 0; host_we = 0; host_addr = '0; host_wdata = '0;
        line_stat = 16'hA5_3C; rx_err = 16'h71_18; rx_byte = 16'hD2_4E;
        irq_pend = 8'h96;
        clear_chan(0); clear_chan(1); m_mic = 8'h00;
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(host_rdata == 0 && tx_load == 0 && rx_take == 0 && chan_rst == 0,
            "R1 outputs", {host_rdata, 4'h0, tx_load, rx_take, chan_rst, 8'h0}, 0);
        chk_outs("R1 regs");
        rreg(1, 12, "R1 RR12 A");

        // R4 idle read returns status; R2 channel decode
        acc(1, 1'b0, 1'b0, 8'h00, d);
        chk(d == 8'hA5, "R4 idle RR0 A", 32'(d), 32'hA5);
        acc(0, 1'b0, 1'b0, 8'h00, d);
        chk(d == 8'h3C, "R2 idle RR0 B", 32'(d), 32'h3C);

        // R3 point high and R12
        wreg(1, 12, 8'h34); wreg(1, 13, 8'h12); wreg(0, 12, 8'hCD);
        chk_outs("R12 const");
        rreg(1, 13, "R5 RR13 A");

        // R3 other modifier codes add nothing: 0x14 -> index 4
        acc(0, 1'b0, 1'b1, 8'h14, d);
        acc(0, 1'b0, 1'b1, 8'h5A, d);
        m_wr[0][4] = 8'h5A;
        rreg(0, 4, "R3 modifier 010");
        rreg(0, 12, "R3 bank untouched");

        // R10 index 0 pointer write
        acc(1, 1'b0, 1'b1, 8'h00, d);
        acc(1, 1'b0, 1'b0, 8'h00, d);
        chk(d == 8'hA5, "R10 idx0 then RR0", 32'(d), 32'hA5);

        // R13 pointer left armed on A while B is used
        acc(1, 1'b0, 1'b1, pbyte(12), d);
        acc(0, 1'b0, 1'b0, 8'h00, d);
        chk(d == 8'h3C, "R13 B idle", 32'(d), 32'h3C);
        acc(1, 1'b0, 1'b0, 8'h00, d);
        chk(d == 8'h34, "R13 A armed", 32'(d), 32'h34);

        // R11 data access between pointer and register write
        acc(1, 1'b0, 1'b1, pbyte(5), d);
        acc(1, 1'b1, 1'b1, 8'hE7, d);
        chk(snap_tx == 2'b10 && tx_byte == 8'hE7, "R11 tx load",
            {snap_tx, tx_byte}, {2'b10, 8'hE7});
        acc(0, 1'b1, 1'b0, 8'h00, d);
        chk(d == 8'h4E && snap_take == 2'b01, "R11 rx take", {snap_take, d}, {2'b01, 8'h4E});
        acc(1, 1'b0, 1'b1, 8'h66, d);
        m_wr[1][5] = 8'h66;
        rreg(1, 5, "R11 pointer kept");

        // R6 pending only on A; R5 mirrors
        rreg(1, 3, "R6 RR3 A");
        rreg(0, 3, "R6 RR3 B");
        wreg(0, 3, 8'h81); wreg(0, 10, 8'h42); wreg(0, 7, 8'h19);
        rreg(0, 9, "R5 RR9"); rreg(0, 11, "R5 RR11"); rreg(0, 14, "R5 RR14");
        rreg(0, 8, "R5 RR8"); rreg(1, 1, "R5 RR1"); rreg(1, 6, "R5 RR6");

        // R7 shared register through both channels
        wreg(0, 9, 8'h2A); chk_outs("R7 via B");
        wreg(1, 9, 8'h15); chk_outs("R7 via A");

        // R8 / R9 reset codes
        wreg(1, 9, 8'h8B); chk_outs("R9 reset A");
        rreg(1, 12, "R9 A cleared"); rreg(0, 4, "R9 B kept");
        wreg(1, 12, 8'h77); wreg(0, 2, 8'h3E);
        wreg(1, 9, 8'h44); chk_outs("R9 reset B");
        rreg(0, 2, "R9 B cleared"); rreg(1, 12, "R9 A kept");
        wreg(0, 13, 8'h55);
        wreg(0, 9, 8'hFF); chk_outs("R8 full reset");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int ch, idx, op;
            ch  = int'($urandom_range(0, 1));
            idx = int'($urandom_range(1, 15));
            op  = int'($urandom_range(0, 19));
            if (op < 8) begin
                if (idx == 9 && $urandom_range(0, 3) != 0) idx = 12;
                wreg(ch, idx, 8'($urandom()));
            end else if (op < 17) begin
                rreg(ch, idx, "R5 random read");
            end else if (op < 18) begin
                acc(ch, 1'b0, 1'b0, 8'h00, d);
                chk(d == exp_rr(ch, 0), "R4 random idle", 32'(d), 32'(exp_rr(ch, 0)));
            end else begin
                line_stat = 16'($urandom()); rx_byte = 16'($urandom());
                irq_pend = 8'($urandom());
            end
        end
        chk_outs("R12 final");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule